// File: doc/BRIEF.md
# Transmit Event Status and Interrupt Unit

This block keeps the transmit-side event flags of a small Ethernet data-link controller. It also holds the interrupt enables for those events and the transmit mode settings. The transmit engine sends one-cycle pulses when a frame goes out cleanly, when its own frame is seen back, on underflow, on a collision, on the sixteenth collision and on a parity error. Those pulses are latched until the host acknowledges them. Carrier sense and a shorted medium arrive as levels and are reported live. The block also counts collisions since the last clean send, and the host sees this count in the upper half of the mode register.

A byte-wide register port with a two-bit address gives the host access. Address 0 reads the event status, and a write to address 0 acknowledges the latched flags whose positions are written as 1. Address 1 holds the interrupt enables. Address 2 holds the four writable mode bits under the read-only collision count. A single active-low line signals any enabled latched event.

Top module: `txev_status_unit`

## Requirements
- R1: A read at address 0 returns the status byte. From bit 7 down the bits are: clean send, carrier sense, own frame seen, medium shorted, underflow, collision, sixteenth collision, parity error. Address 3 reads 0x00.
- R2: An event pulse on a latched input (bits 7, 5, 3, 2, 1, 0) sets its status bit from the next cycle on. The bit stays set until it is acknowledged or reset.
- R3: A write to address 0 clears each latched bit whose position in the written byte is 1 and leaves the others alone. If an event pulse comes in the same cycle as its clear, the bit stays set.
- R4: Status bits 6 and 4 follow the carrier-sense and medium-short input levels in the same cycle. Writes do not change them, and they never assert the interrupt.
- R5: Address 1 is the interrupt enable register and can be read and written. Only bits 7, 5, 3, 2, 1 and 0 store values. Bits 6 and 4 always read 0.
- R6: `tx_irq_n` is 0 exactly when some latched status bit is set and its enable bit is also set.
- R7: Bits 3:0 at address 2 can be read and written. Writes to bits 7:4 are ignored, and those bits read the collision count.
- R8: Each collision pulse adds 1 to the collision count. The count holds at 15 once it gets there.
- R9: A clean-send pulse sets the count to 0. It wins over a collision in the same cycle.
- R10: A sixteenth-collision pulse sets only status bit 1 and does not change the count.
- R11: A synchronous active-high reset clears the latched status, the enables, the mode bits and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_sent_ok | input | 1 | Pulse: frame sent cleanly |
| carrier_sense | input | 1 | Level: carrier present |
| ev_self_rx | input | 1 | Pulse: own frame seen back |
| media_short | input | 1 | Level: medium shorted |
| ev_underflow | input | 1 | Pulse: transmit underflow |
| ev_coll | input | 1 | Pulse: collision |
| ev_coll16 | input | 1 | Pulse: sixteenth collision |
| ev_parity | input | 1 | Pulse: parity error |
| host_addr | input | 2 | Register address |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data (combinational) |
| tx_irq_n | output | 1 | Interrupt, active low |

## Verification
The embedded assertions check on every cycle that each latched flag sets, holds and clears correctly, including a set arriving together with its clear. They also check that the count resets, increments and saturates as required, that enable and mode writes are stored, and that an enabled underflow asserts the interrupt. Only the bench scenarios can show the exact read-back byte at each address. The same goes for the live carrier and short bits, which must never reach the interrupt, for writes being ignored in the count nibble and in the unused enable bits, and for the reset values seen at the port.

// File: rtl/txev_pkg.sv
package txev_pkg;
   localparam int STAT_W = 8;
   localparam int BIT_SENT   = 7;
   localparam int BIT_CARR   = 6;
   localparam int BIT_SELF   = 5;
   localparam int BIT_SHORT  = 4;
   localparam int BIT_UFLW   = 3;
   localparam int BIT_COLL   = 2;
   localparam int BIT_COLL16 = 1;
   localparam int BIT_PAR    = 0;
   // positions that latch pulses; the rest are live levels
   localparam logic [STAT_W-1:0] LATCH_MAP = 8'hAF;

   typedef enum logic [1:0] {
      REG_STATUS = 2'd0,
      REG_ENABLE = 2'd1,
      REG_MODE   = 2'd2,
      REG_SPARE  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/txev_event_bank.sv
module txev_event_bank #(
   parameter int                W        = 8,
   parameter logic [W-1:0]      LAT_MAP  = 8'hAF,
   parameter bit                SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] ev_in,
   input  logic         clr_we,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] lat_q,
   output logic [W-1:0] status
);
   if (W < 1) begin : g_bad_w
      $error("event bank width must be positive");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (LAT_MAP[i]) begin : g_latched
         logic hit_clr;
         assign hit_clr = clr_we & clr_bits[i];
         if (SET_WINS) begin : g_setpri
            always_ff @(posedge clk) begin
               if (rst)            lat_q[i] <= 1'b0;
               else if (ev_in[i])  lat_q[i] <= 1'b1;
               else if (hit_clr)   lat_q[i] <= 1'b0;
            end
         end else begin : g_clrpri
            always_ff @(posedge clk) begin
               if (rst)            lat_q[i] <= 1'b0;
               else if (hit_clr)   lat_q[i] <= 1'b0;
               else if (ev_in[i])  lat_q[i] <= 1'b1;
            end
         end
         assign status[i] = lat_q[i];

         // R2
         ev_sets_chk: assert property (@(posedge clk) disable iff (rst)
            ev_in[i] && SET_WINS |=> lat_q[i]);
         // R2
         flag_holds_chk: assert property (@(posedge clk) disable iff (rst)
            lat_q[i] && !hit_clr |=> lat_q[i]);
         // R3
         clr_works_chk: assert property (@(posedge clk) disable iff (rst)
            hit_clr && !ev_in[i] |=> !lat_q[i]);
      end else begin : g_live
         assign lat_q[i]  = 1'b0;
         assign status[i] = ev_in[i];
      end
   end
endmodule

// File: rtl/txev_coll_counter.sv
module txev_coll_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             coll,
   input  logic             sent_ok,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("collision counter width out of range");
   end

   always_ff @(posedge clk) begin
      if (rst)                          count <= '0;
      else if (sent_ok)                 count <= '0;
      else if (coll && count != CNT_MAX) count <= count + 1'b1;
   end

   // R9
   sent_resets_chk: assert property (@(posedge clk) disable iff (rst)
      sent_ok |=> count == '0);
   // R8
   sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
      coll && !sent_ok && count == CNT_MAX |=> count == CNT_MAX);
   // R8
   step_one_chk: assert property (@(posedge clk) disable iff (rst)
      coll && !sent_ok && count != CNT_MAX |=> count == $past(count) + 1'b1);
   // R10
   idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
      !coll && !sent_ok |=> $stable(count));
endmodule

// File: rtl/txev_reg_port.sv
module txev_reg_port
   import txev_pkg::*;
#(
   parameter int                DATA_W  = 8,
   parameter int                CNT_W   = 4,
   parameter int                ADDR_W  = 2,
   parameter logic [DATA_W-1:0] EN_MAP  = 8'hAF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] status,
   input  logic [CNT_W-1:0]  count,
   output logic [DATA_W-1:0] enable_q,
   output logic              clr_we,
   output logic [DATA_W-1:0] clr_bits,
   output logic [DATA_W-1:0] rdata
);
   localparam int MODE_W = DATA_W - CNT_W;

   if (MODE_W < 1) begin : g_bad_split
      $error("count field must leave room for mode bits");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("address needs at least two bits");
   end

   logic [MODE_W-1:0] mode_q;
   logic sel_stat, sel_en, sel_mode;

   assign sel_stat = (addr == ADDR_W'(REG_STATUS));
   assign sel_en   = (addr == ADDR_W'(REG_ENABLE));
   assign sel_mode = (addr == ADDR_W'(REG_MODE));

   assign clr_we   = wr & sel_stat;
   assign clr_bits = wdata;

   always_ff @(posedge clk) begin
      if (rst) begin
         enable_q <= '0;
         mode_q   <= '0;
      end else if (wr) begin
         if (sel_en)   enable_q <= wdata & EN_MAP;
         if (sel_mode) mode_q   <= wdata[MODE_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (sel_stat)      rdata = status;
      else if (sel_en)   rdata = enable_q;
      else if (sel_mode) rdata = {count, mode_q};
   end

   // R5
   enable_store_chk: assert property (@(posedge clk) disable iff (rst)
      wr && sel_en |=> enable_q == ($past(wdata) & EN_MAP));
   // R7
   mode_store_chk: assert property (@(posedge clk) disable iff (rst)
      wr && sel_mode |=> mode_q == $past(wdata[MODE_W-1:0]));
endmodule

// File: rtl/txev_status_unit.sv
module txev_status_unit
   import txev_pkg::*;
#(
   parameter int CNT_W  = 4,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ev_sent_ok,
   input  logic              carrier_sense,
   input  logic              ev_self_rx,
   input  logic              media_short,
   input  logic              ev_underflow,
   input  logic              ev_coll,
   input  logic              ev_coll16,
   input  logic              ev_parity,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic [STAT_W-1:0] host_wdata,
   output logic [STAT_W-1:0] host_rdata,
   output logic              tx_irq_n
);
   logic [STAT_W-1:0] ev_vec, lat_q, status, enable_q, clr_bits;
   logic [CNT_W-1:0]  count;
   logic              clr_we;

   always_comb begin
      ev_vec             = '0;
      ev_vec[BIT_SENT]   = ev_sent_ok;
      ev_vec[BIT_CARR]   = carrier_sense;
      ev_vec[BIT_SELF]   = ev_self_rx;
      ev_vec[BIT_SHORT]  = media_short;
      ev_vec[BIT_UFLW]   = ev_underflow;
      ev_vec[BIT_COLL]   = ev_coll;
      ev_vec[BIT_COLL16] = ev_coll16;
      ev_vec[BIT_PAR]    = ev_parity;
   end

   txev_event_bank #(.W(STAT_W), .LAT_MAP(LATCH_MAP), .SET_WINS(1'b1)) bank_i (
      .clk(clk), .rst(rst), .ev_in(ev_vec), .clr_we(clr_we),
      .clr_bits(clr_bits), .lat_q(lat_q), .status(status));

   txev_coll_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst(rst), .coll(ev_coll), .sent_ok(ev_sent_ok),
      .count(count));

   txev_reg_port #(.DATA_W(STAT_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
                   .EN_MAP(LATCH_MAP)) port_i (
      .clk(clk), .rst(rst), .addr(host_addr), .wr(host_wr),
      .wdata(host_wdata), .status(status), .count(count),
      .enable_q(enable_q), .clr_we(clr_we), .clr_bits(clr_bits),
      .rdata(host_rdata));

   assign tx_irq_n = ~|(lat_q & enable_q);

   // R6
   irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
      ev_underflow && enable_q[BIT_UFLW] && !(host_wr && host_addr == ADDR_W'(REG_ENABLE))
      |=> !tx_irq_n);
   // R4
   live_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
      lat_q == '0 |-> tx_irq_n);
endmodule

// File: tb/txev_status_unit_tb_top.sv
module txev_status_unit_tb_top;
   logic clk = 1'b0;
   logic rst;
   logic [7:0] ev;
   logic [1:0] addr;
   logic wr;
   logic [7:0] wdata;
   logic [7:0] rdata;
   logic irq_n;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   txev_status_unit dut_i (
      .clk(clk), .rst(rst),
      .ev_sent_ok(ev[7]), .carrier_sense(ev[6]), .ev_self_rx(ev[5]),
      .media_short(ev[4]), .ev_underflow(ev[3]), .ev_coll(ev[2]),
      .ev_coll16(ev[1]), .ev_parity(ev[0]),
      .host_addr(addr), .host_wr(wr), .host_wdata(wdata),
      .host_rdata(rdata), .tx_irq_n(irq_n));

   // fields: ev, wr, waddr, wdata, raddr, exp_rdata, exp_irq_n
   localparam int NV = 18;
   localparam logic [29:0] VEC [NV] = '{
      {8'h08, 1'b0, 2'd0, 8'h00, 2'd0, 8'h08, 1'b1}, // R2 underflow latches
      {8'h00, 1'b1, 2'd1, 8'hFF, 2'd1, 8'hAF, 1'b0}, // R5 R6
      {8'h00, 1'b1, 2'd0, 8'h08, 2'd0, 8'h00, 1'b1}, // R3
      {8'h04, 1'b0, 2'd0, 8'h00, 2'd2, 8'h10, 1'b0}, // R8
      {8'h04, 1'b0, 2'd0, 8'h00, 2'd2, 8'h20, 1'b0}, // R8
      {8'h00, 1'b1, 2'd2, 8'hFF, 2'd2, 8'h2F, 1'b0}, // R7
      {8'h80, 1'b0, 2'd0, 8'h00, 2'd2, 8'h0F, 1'b0}, // R9
      {8'h00, 1'b0, 2'd0, 8'h00, 2'd0, 8'h84, 1'b1 ^ 1'b1}, // R1
      {8'h00, 1'b1, 2'd0, 8'h80, 2'd0, 8'h04, 1'b0}, // R3
      {8'h02, 1'b1, 2'd0, 8'h04, 2'd2, 8'h0F, 1'b0}, // R10
      {8'h00, 1'b1, 2'd1, 8'h01, 2'd1, 8'h01, 1'b1}, // R6
      {8'h01, 1'b0, 2'd0, 8'h00, 2'd0, 8'h03, 1'b0}, // R2
      {8'h01, 1'b1, 2'd0, 8'h01, 2'd0, 8'h03, 1'b0}, // R3 set wins
      {8'h00, 1'b1, 2'd0, 8'hFF, 2'd0, 8'h00, 1'b1}, // R3
      {8'h20, 1'b0, 2'd0, 8'h00, 2'd0, 8'h20, 1'b1}, // R6 masked
      {8'h00, 1'b1, 2'd1, 8'h20, 2'd3, 8'h00, 1'b0}, // R1 spare
      {8'h04, 1'b0, 2'd0, 8'h00, 2'd2, 8'h1F, 1'b0}, // R8
      {8'h84, 1'b0, 2'd0, 8'h00, 2'd2, 8'h0F, 1'b0}  // R9 wins
   };

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic step(input logic [7:0] e, input logic w, input logic [1:0] a,
                       input logic [7:0] d, input logic [1:0] ra);
      ev = e; wr = w; addr = a; wdata = d;
      @(negedge clk);
      ev = 8'h00; wr = 1'b0; addr = ra; wdata = 8'h00;
      #1;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; ev = 8'h00; addr = 2'd0; wr = 1'b0; wdata = 8'h00;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      // R11 reset state
      check("R11 status", rdata, 8'h00);
      check("R11 irq", {7'd0, irq_n}, 8'h01);
      addr = 2'd1; #1; check("R11 enable", rdata, 8'h00);
      addr = 2'd2; #1; check("R11 mode", rdata, 8'h00);

      for (int k = 0; k < NV; k++) begin
         logic [29:0] v;
         v = VEC[k];
         step(v[29:22], v[21], v[20:19], v[18:11], v[10:9]);
         check($sformatf("vec%0d rdata", k), rdata, v[8:1]);
         check($sformatf("vec%0d irq", k), {7'd0, irq_n}, {7'd0, v[0]});
      end

      // clean slate: ack all, enable all
      step(8'h00, 1'b1, 2'd0, 8'hFF, 2'd0);
      step(8'h00, 1'b1, 2'd1, 8'hFF, 2'd0);
      // R4 live carrier and short reflect level, no irq, writes ignored
      ev = 8'h50; wr = 1'b1; addr = 2'd0; wdata = 8'h50; #1;
      check("R4 live bits", rdata, 8'h50);
      @(negedge clk); wr = 1'b0; #1;
      check("R4 live after write", rdata, 8'h50);
      check("R4 no irq", {7'd0, irq_n}, 8'h01);
      ev = 8'h00; #1;
      check("R4 drop", rdata, 8'h00);

      // R8 saturation after 20 collisions
      for (int n = 0; n < 20; n++) step(8'h04, 1'b0, 2'd0, 8'h00, 2'd2);
      check("R8 saturate", rdata, 8'hFF);
      // R7 upper nibble write ignored
      step(8'h00, 1'b1, 2'd2, 8'h05, 2'd2);
      check("R7 count kept", rdata, 8'hF5);
      // R10 sixteenth alone
      step(8'h00, 1'b1, 2'd0, 8'hFF, 2'd0);
      step(8'h02, 1'b0, 2'd0, 8'h00, 2'd0);
      check("R10 status", rdata, 8'h02);
      addr = 2'd2; #1; check("R10 count", rdata, 8'hF5);

      // R11 reset mid-run
      rst = 1'b1; @(negedge clk); rst = 1'b0; addr = 2'd0; #1;
      check("R11 status after", rdata, 8'h00);
      addr = 2'd1; #1; check("R11 enable after", rdata, 8'h00);
      addr = 2'd2; #1; check("R11 mode after", rdata, 8'h00);
      check("R11 irq after", {7'd0, irq_n}, 8'h01);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule